// File: doc/BRIEF.md
# Variable-Resolution Converter Serial Sequencer

This block is the device-side digital controller for a two-wire converter link. The host drives a serial clock line, and the block answers on a single data line. While the device sleeps, both lines rest high. A falling clock edge in sleep starts a conversion and latches a two-bit channel address. Further falling edges that arrive inside a fixed window after the start each remove one bit of resolution. Each removed bit also halves the conversion time. Every accepted edge is acknowledged on the data line.

When the modelled conversion time has elapsed, the block raises the data line and waits with the result. The host then clocks the word out, one bit per falling edge, sign bit first. The analog converter is replaced by a parallel 16-bit result input, which is sampled when the conversion completes. The clock line is synchronised into the internal clock domain before any edge is detected.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the data line is high and the channel output is 0. A falling clock edge in sleep starts a conversion, and the channel output then takes the value of `addr_i` at that edge.
- R2: After the start edge the data line stays high while the clock is low, and goes low once the clock rises again (data pattern 1-1-0 across clock high-low-high).
- R3: Each further falling edge within `WIN_CYC` internal cycles of the start lowers the resolution by one bit. The data line is high while the clock is low, and low after the clock rises (pattern 0-1-0).
- R4: At most 6 reductions are accepted, so the minimum resolution is 10 bits. Later edges inside the window give no acknowledge and do not change the length of the word.
- R5: Falling edges after the window has closed, while the conversion is still running, are ignored, and the data line stays low.
- R6: The conversion completes after max(`BASE_CYC` >> n, `WIN_CYC`) internal cycles, where n is the number of accepted reductions. The data line then goes high.
- R7: Readout sends 16−n bits, one per falling edge, in two's complement, starting with the sign bit and going from MSB down to LSB. These bits are the top 16−n bits of `result_i` as captured at completion, truncated.
- R8: The code with only the sign bit set (1 followed by zeros) is never sent at any resolution. It is replaced by the same code with its LSB set.
- R9: A full cycle takes exactly 17 falling edges. After the last data bit, the next clock rise returns the block to sleep with the data line high, and the next falling edge starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| addr_i | input | 2 | Channel address, latched at the start edge |
| result_i | input | 16 | Parallel conversion result, sampled at completion |
| sdat_o | output | 1 | Serial data line: acknowledges, ready flag and result bits |
| chan_o | output | 2 | Channel selected for the current conversion |

## Verification
The bench builds the block with `WIN_CYC` = 128 and `BASE_CYC` = 1024. With these values, eight reduction edges fit inside the window, so the cap of six can be exercised. The reduced conversion times of 1024, 256 and 128 cycles can all be checked in a short run. At the fully reduced setting the window itself sets the completion time. A full-resolution conversion leaves room for a falling edge after the window closes, which exercises the ignore rule.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DATA_W  = 16;
  localparam int RED_MAX = 6;
  localparam int RED_W   = $clog2(RED_MAX + 1);
  localparam int IDX_W   = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    ST_SLEEP,
    ST_CONV,
    ST_READY,
    ST_READ
  } seq_state_e;

  // conversion length shrinks by half per accepted reduction
  function automatic int unsigned conv_cycles(input int unsigned base,
                                              input logic [RED_W-1:0] red);
    return base >> red;
  endfunction

  // keep the top DATA_W-red bits (MSB aligned), steer off the reserved code
  function automatic logic [DATA_W-1:0] fmt_word(input logic [DATA_W-1:0] raw,
                                                 input logic [RED_W-1:0] red);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] w;
    mask = {DATA_W{1'b1}} << red;
    w    = raw & mask;
    if (w == {1'b1, {(DATA_W-1){1'b0}}})
      w = w | (DATA_W'(1) << red);
    return w;
  endfunction

endpackage

// File: rtl/adc_sclk_sync.sv
module adc_sclk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= sclk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;
  assign rise_o = ~s3_q & s2_q;
endmodule

// File: rtl/adc_window_ctl.sv
module adc_window_ctl
  import adc_seq_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 256,
  parameter int unsigned BASE_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             fall_i,
  output logic             win_open_o,
  output logic             accept_o,
  output logic [RED_W-1:0] red_o,
  output logic             done_o
);
  localparam int unsigned SPAN = (BASE_CYC > WIN_CYC) ? BASE_CYC : WIN_CYC;
  localparam int CW = $clog2(SPAN + 2);

  logic [CW-1:0]    elapsed_q;
  logic [RED_W-1:0] red_q;

  assign win_open_o = active_i && (32'(elapsed_q) < WIN_CYC);
  assign accept_o   = win_open_o && fall_i && (red_q < RED_W'(RED_MAX));
  assign done_o     = active_i && !win_open_o &&
                      (32'(elapsed_q) >= conv_cycles(BASE_CYC, red_q));
  assign red_o      = red_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      red_q     <= '0;
    end else if (start_i) begin
      elapsed_q <= '0;
      red_q     <= '0;
    end else begin
      if (active_i && !(&elapsed_q))
        elapsed_q <= elapsed_q + 1'b1;
      if (accept_o)
        red_q <= red_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 256,
  parameter int unsigned BASE_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdat_o,
  output logic [1:0]        chan_o
);
  seq_state_e        state_q;
  logic              fall_evt, rise_evt;
  logic              start_evt, active;
  logic              win_open, accept_evt, done_evt;
  logic [RED_W-1:0]  red;
  logic [DATA_W-1:0] word_q, word_sh;
  logic [IDX_W-1:0]  bit_idx_q, nbits;
  logic              sdat_q;

  adc_sclk_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .fall_o (fall_evt),
    .rise_o (rise_evt)
  );

  assign start_evt = (state_q == ST_SLEEP) && fall_evt;
  assign active    = (state_q == ST_CONV);

  adc_window_ctl #(.WIN_CYC(WIN_CYC), .BASE_CYC(BASE_CYC)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_evt),
    .active_i   (active),
    .fall_i     (fall_evt),
    .win_open_o (win_open),
    .accept_o   (accept_evt),
    .red_o      (red),
    .done_o     (done_evt)
  );

  assign nbits   = IDX_W'(DATA_W) - IDX_W'(red);
  assign word_sh = word_q << bit_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SLEEP;
      sdat_q    <= 1'b1;
      chan_o    <= '0;
      word_q    <= '0;
      bit_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_SLEEP: begin
          sdat_q <= 1'b1;
          if (fall_evt) begin
            chan_o  <= addr_i;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (done_evt) begin
            word_q  <= fmt_word(result_i, red);
            sdat_q  <= 1'b1;
            state_q <= ST_READY;
          end else if (accept_evt) begin
            sdat_q <= 1'b1;
          end else if (rise_evt || !win_open) begin
            sdat_q <= 1'b0;
          end
        end
        ST_READY: begin
          sdat_q <= 1'b1;
          if (fall_evt) begin
            sdat_q    <= word_q[DATA_W-1];
            bit_idx_q <= IDX_W'(1);
            state_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (fall_evt && bit_idx_q < nbits) begin
            sdat_q    <= word_sh[DATA_W-1];
            bit_idx_q <= bit_idx_q + 1'b1;
          end else if (rise_evt && bit_idx_q == nbits) begin
            sdat_q  <= 1'b1;
            state_q <= ST_SLEEP;
          end
        end
        default: state_q <= ST_SLEEP;
      endcase
    end
  end

  assign sdat_o = sdat_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input seq_state_e        state_q,
  input logic              sdat_o,
  input logic              win_open,
  input logic              start_evt,
  input logic              accept_evt,
  input logic              done_evt,
  input logic [RED_W-1:0]  red,
  input logic [DATA_W-1:0] word_q,
  input logic [1:0]        addr_i,
  input logic [1:0]        chan_o
);
  AST_START_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> chan_o == $past(addr_i)); // R1

  AST_RED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> red == $past(red) + 1'b1); // R3

  AST_RED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    red <= RED_W'(RED_MAX)); // R4

  AST_ACK_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && $past(state_q) == ST_CONV && sdat_o) |-> $past(win_open)); // R5

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (sdat_o && state_q == ST_READY)); // R6

  AST_RED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ) |-> $stable(red)); // R7

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY) |-> word_q != {1'b1, {(DATA_W-1){1'b0}}}); // R8
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_q    (state_q),
  .sdat_o     (sdat_o),
  .win_open   (win_open),
  .start_evt  (start_evt),
  .accept_evt (accept_evt),
  .done_evt   (done_evt),
  .red        (red),
  .word_q     (word_q),
  .addr_i     (addr_i),
  .chan_o     (chan_o)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int unsigned T_WIN  = 128;
  localparam int unsigned T_BASE = 1024;
  localparam int HOLD = 6;

  typedef struct {
    logic  b;
    string tag;
  } exp_bit_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic [1:0]  addr = '0;
  logic [15:0] res = '0;
  wire         sdat;
  wire  [1:0]  chan;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  exp_bit_t exp_q[$];
  logic  obs_bit;
  event  bit_ev;

  adc_seq_ctrl #(.WIN_CYC(T_WIN), .BASE_CYC(T_BASE)) uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .addr_i(addr),
    .result_i(res), .sdat_o(sdat), .chan_o(chan)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares every read-out bit with the scoreboard head
  initial begin
    forever begin
      @(bit_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected data bit", int'(obs_bit), -1);
      end else begin
        exp_bit_t e;
        e = exp_q.pop_front();
        chk(obs_bit === e.b, e.tag, "data bit", int'(obs_bit), int'(e.b));
      end
    end
  end

  // driver: one full convert and read cycle
  task automatic run(input logic [1:0] a, input logic [15:0] r,
                     input int n_edges, input bit late_edge);
    int red, nb, v, t0, dur, expd, guard;
    string tag;
    red = (n_edges > 6) ? 6 : n_edges;
    nb  = 16 - red;
    v   = int'(r >> red);
    tag = "R7";
    if (v == (1 << (nb - 1))) begin
      v   = v + 1;
      tag = "R8";
    end
    for (int i = 0; i < nb; i++) begin
      exp_bit_t e;
      e.b   = v[nb-1-i];
      e.tag = tag;
      exp_q.push_back(e);
    end
    addr = a;
    res  = r;
    waitn(1);
    t0   = cyc;
    sclk = 1'b0;
    waitn(HOLD);
    chk(sdat === 1'b1, "R2", "start ack while low", int'(sdat), 1);
    sclk = 1'b1;
    waitn(HOLD);
    chk(sdat === 1'b0, "R2", "start ack after rise", int'(sdat), 0);
    chk(chan === a, "R1", "channel latched", int'(chan), int'(a));
    for (int k = 0; k < n_edges; k++) begin
      sclk = 1'b0;
      waitn(HOLD);
      if (k < 6)
        chk(sdat === 1'b1, "R3", "reduction ack", int'(sdat), 1);
      else
        chk(sdat === 1'b0, "R4", "edge past cap", int'(sdat), 0);
      sclk = 1'b1;
      waitn(HOLD);
      chk(sdat === 1'b0, "R3", "ack released", int'(sdat), 0);
    end
    if (late_edge) begin
      while (cyc - t0 < int'(T_WIN) + 20) waitn(1);
      sclk = 1'b0;
      waitn(HOLD);
      chk(sdat === 1'b0, "R5", "late edge ignored", int'(sdat), 0);
      sclk = 1'b1;
      waitn(HOLD);
    end
    guard = 0;
    while (sdat !== 1'b1 && guard < 5000) begin
      waitn(1);
      guard++;
    end
    dur  = cyc - t0;
    expd = int'(T_BASE >> red);
    if (expd < int'(T_WIN)) expd = int'(T_WIN);
    chk(dur >= expd && dur <= expd + 8, "R6", "conversion cycles", dur, expd);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      waitn(HOLD);
      obs_bit = sdat;
      -> bit_ev;
      sclk = 1'b1;
      waitn(HOLD);
    end
    chk(sdat === 1'b1, "R9", "sleep after last bit", int'(sdat), 1);
    chk(exp_q.size() == 0, "R9", "bits left in scoreboard", exp_q.size(), 0);
    waitn(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    waitn(5);
    rst_n = 1'b1;
    waitn(3);
    chk(sdat === 1'b1, "R1", "reset sdat", int'(sdat), 1);
    chk(chan === 2'd0, "R1", "reset channel", int'(chan), 0);
    run(2'd1, 16'h1234, 0, 1'b0);
    run(2'd2, 16'h8000, 0, 1'b1);
    run(2'd3, 16'hFFFF, 3, 1'b0);
    run(2'd0, 16'h8000, 6, 1'b0);
    run(2'd2, 16'h7FFF, 8, 1'b0);
    run(2'd1, 16'h8040, 6, 1'b0);
    run(2'd3, 16'hA5C3, 2, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule